// File: doc/BRIEF.md
# MDIO Management Master with Register Port

This block is a bus master for the two-wire management interface of Ethernet PHYs. Software controls it through four 32-bit registers on a simple single-cycle register port: a configuration/status word, a control word, a data word and an address word. Some register writes start a frame as a side effect. A data write sends a write frame. A control write with the read bit set sends a read frame. An address write sends an address frame, but only while the extended (Clause 45) format is selected.

The block makes the management clock from the system clock through a programmable divider. It drives the data line through a separate output and output-enable pair and samples the line on the rising management clock edge. Software polls a busy flag between the steps of an access. When the addressed device does not answer a read, a read-error flag reports it.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the status word reads 0x00000400 (divider field 4, everything else 0), the control, data and address words read 0, MDC is low and the data line is released (mdio_oe low).
- R2: The registers sit at word offsets 12 (status), 13 (control), 14 (data) and 15 (address); reads return the 16-bit content zero-extended. Writes to offsets 0 to 11 change nothing and those offsets read 0. Status bit 6 (format, 1 = Clause 45) and bits 15:8 (divider) are writable. Control bits 4:0 (device/register), 9:5 (port), 10 (no preamble), 11 (scan) and 14 (post-increment) read back, and control bit 15 (read) always reads 0.
- R3: In Clause 22 format, a data write sends 32 ones, start 01, opcode 01, port, register, turnaround 10 and the 16 data bits, MSB first.
- R4: In Clause 22 format, a control write with bit 15 set sends 32 ones, 01, opcode 10, port and register, then releases the line from the first turnaround bit on. It samples 16 data bits MSB first on rising MDC edges, and the result reads from data bits 15:0 once busy clears.
- R5: When the device does not pull the second turnaround bit low, status bit 1 is set at the end of the read. The next read launch clears it.
- R6: In Clause 45 format, an address write sends 32 ones, start 00, opcode 00, port, device, turnaround 10 and the 16 address bits. In Clause 22 format an address write only stores the value and sends nothing.
- R7: In Clause 45 format a data write uses opcode 01 and a read uses opcode 11, both with start 00.
- R8: A Clause 45 read with control bit 14 set uses opcode 10, and the address word increments by one when that read completes.
- R9: With control bit 10 set the preamble is left out, so a frame carries 32 driven-or-sampled bit slots instead of 64.
- R10: MDC stays low while idle. While busy, MDC is high for H system clocks and low for H system clocks, where H is the divider field (0 acts as 1).
- R11: For a frame of B bit slots (64, or 32 without preamble), status bit 0 reads 1 for exactly 2*H*(B+1)+1 consecutive cycles from the cycle after the launching write.
- R12: While busy, writes to the control, data and address words are ignored: nothing is stored and no frame starts. Status writes are still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 4 | Register word offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data line value driven by the master |
| mdio_oe | output | 1 | Data line output enable, high while the master drives |
| mdio_in | input | 1 | Data line value as seen at the pin |

## Verification
A wrong bit index or shift position shows up at once as a misplaced opcode, address or data bit in the serial stream, or as a wrong read result, in the first frame that uses that field. A divider or bit-counter fault changes how long busy stays set, and that count is measured exactly for every frame. A stale job kind or a bad post-increment shows in the data or address readback on the cycle busy clears. A busy gate that is open at the wrong time lets a mid-frame write corrupt the stored data or add a second frame to the captured stream.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int DIV_W = 8;

    // status word bit positions
    localparam int STAT_BUSY_BIT  = 0;
    localparam int STAT_RDERR_BIT = 1;
    localparam int STAT_C45_BIT   = 6;
    localparam int STAT_DIV_LSB   = 8;

    // control word bit positions
    localparam int CTL_DEV_LSB   = 0;
    localparam int CTL_PORT_LSB  = 5;
    localparam int CTL_NOPRE_BIT = 10;
    localparam int CTL_SCAN_BIT  = 11;
    localparam int CTL_INC_BIT   = 14;
    localparam int CTL_RD_BIT    = 15;

    localparam logic [1:0] ST_C22 = 2'b01;
    localparam logic [1:0] ST_C45 = 2'b00;

    typedef enum logic [1:0] {
        JOB_NONE  = 2'd0,
        JOB_ADDR  = 2'd1,
        JOB_WRITE = 2'd2,
        JOB_READ  = 2'd3
    } job_e;

    typedef struct packed {
        logic [1:0]       st;
        logic [1:0]       op;
        logic [4:0]       port;
        logic [4:0]       dev;
        logic [15:0]      payload;
        logic             rd;
        logic             no_pre;
        logic [DIV_W-1:0] half;
    } frame_t;

    function automatic logic [1:0] pick_opcode(input logic c45, input job_e job, input logic inc);
        logic [1:0] op;
        op = 2'b00;
        if (c45) begin
            case (job)
                JOB_WRITE: op = 2'b01;
                JOB_READ:  op = inc ? 2'b10 : 2'b11;
                default:   op = 2'b00;
            endcase
        end else begin
            op = (job == JOB_READ) ? 2'b10 : 2'b01;
        end
        return op;
    endfunction

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div
    import mdio_mgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             mdc,
    output logic             rise_p,
    output logic             fall_p
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
        logic             rise;
        logic             fall;
    } div_t;

    div_t q, d;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim = (half == '0) ? '0 : half - DIV_W'(1);
        d   = q;
        d.rise = 1'b0;
        d.fall = 1'b0;
        if (!run) begin
            d = '0;
        end else if (q.cnt == lim) begin
            d.cnt  = '0;
            d.mdc  = ~q.mdc;
            d.rise = ~q.mdc;
            d.fall = q.mdc;
        end else begin
            d.cnt = q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mdc    = q.mdc;
    assign rise_p = q.rise;
    assign fall_p = q.fall;

    // R10
    clk_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc);

    // R10
    rise_marks_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_p |-> (mdc && !$past(mdc)));

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_mgmt_pkg::*;
#(
    parameter int PRE_BITS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  frame_t           frame,
    input  logic             rise_p,
    input  logic             fall_p,
    input  logic             mdio_in,
    output logic             busy,
    output logic             run,
    output logic [DIV_W-1:0] half,
    output logic             mdio_out,
    output logic             mdio_oe,
    output logic             done,
    output logic [15:0]      rd_word,
    output logic             rd_fail
);

    localparam int FRAME_W = PRE_BITS + 32;
    localparam int IDX_W   = $clog2(FRAME_W + 1);
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(FRAME_W);
    localparam logic [IDX_W-1:0] TA_IDX    = IDX_W'(PRE_BITS + 14);
    localparam logic [IDX_W-1:0] TA2_IDX   = IDX_W'(PRE_BITS + 15);
    localparam logic [IDX_W-1:0] DATA_IDX  = IDX_W'(PRE_BITS + 16);
    localparam logic [IDX_W-1:0] NOPRE_IDX = IDX_W'(PRE_BITS);

    typedef struct packed {
        logic               active;
        logic [IDX_W-1:0]   idx;
        logic [FRAME_W-1:0] bits;
        logic               rd;
        logic [15:0]        shreg;
        logic               ta_bad;
        logic [DIV_W-1:0]   half;
    } eng_t;

    eng_t q, d;
    logic               last_bit;
    logic [FRAME_W-1:0] full_vec;

    always_comb begin
        full_vec = {{PRE_BITS{1'b1}}, frame.st, frame.op, frame.port, frame.dev,
                    (frame.rd ? 2'b11 : 2'b10), frame.payload};
        last_bit = (q.idx == LAST_IDX);
        d    = q;
        done = 1'b0;
        if (q.active) begin
            if (rise_p && q.rd) begin
                if (q.idx == TA2_IDX)
                    d.ta_bad = mdio_in;
                if (q.idx >= DATA_IDX && !last_bit)
                    d.shreg = {q.shreg[14:0], mdio_in};
            end
            if (fall_p) begin
                if (last_bit) begin
                    d.active = 1'b0;
                    done     = 1'b1;
                end else begin
                    d.idx  = q.idx + IDX_W'(1);
                    d.bits = {q.bits[FRAME_W-2:0], 1'b1};
                end
            end
        end else if (start) begin
            d.active = 1'b1;
            d.idx    = frame.no_pre ? NOPRE_IDX : '0;
            d.bits   = frame.no_pre ? (full_vec << PRE_BITS) : full_vec;
            d.rd     = frame.rd;
            d.shreg  = '0;
            d.ta_bad = 1'b0;
            d.half   = frame.half;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy     = q.active;
    assign run      = q.active && !done;
    assign half     = q.half;
    assign mdio_oe  = q.active && !last_bit && !(q.rd && q.idx >= TA_IDX);
    assign mdio_out = last_bit ? 1'b1 : q.bits[FRAME_W-1];
    assign rd_word  = q.shreg;
    assign rd_fail  = q.ta_bad;

    // R10
    edge_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_p, fall_p}));

    // R11
    done_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> fall_p);

    // R9
    start_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && q.idx == ($past(frame.no_pre) ? NOPRE_IDX : '0)));

endmodule

// File: rtl/mdio_cfg_regs.sv
module mdio_cfg_regs
    import mdio_mgmt_pkg::*;
#(
    parameter int               ADDR_W    = 4,
    parameter int               BASE_WORD = 12,
    parameter logic [DIV_W-1:0] DIV_RESET = 8'd4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              busy,
    input  logic              done,
    input  logic [15:0]       rd_word,
    input  logic              rd_fail,
    output logic              start,
    output frame_t            frame
);

    localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(BASE_WORD);
    localparam logic [ADDR_W-1:0] OFS_CTL  = ADDR_W'(BASE_WORD + 1);
    localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(BASE_WORD + 2);
    localparam logic [ADDR_W-1:0] OFS_ADDR = ADDR_W'(BASE_WORD + 3);

    typedef struct packed {
        logic             c45;
        logic [DIV_W-1:0] div;
        logic             rd_err;
        logic [4:0]       dev;
        logic [4:0]       port;
        logic             no_pre;
        logic             scan;
        logic             inc;
        logic [15:0]      data;
        logic [15:0]      addr;
        job_e             job;
        logic             job_inc;
    } regs_t;

    regs_t q, d;
    job_e  job_new;
    logic  wr_stat, wr_ctl, wr_data, wr_addr;
    logic  unused_wbits;

    assign unused_wbits = ^{bus_wdata[31:16], bus_wdata[13:12], bus_wdata[7], bus_wdata[5:0]};

    always_comb begin
        wr_stat = bus_we && (bus_addr == OFS_STAT);
        wr_ctl  = bus_we && (bus_addr == OFS_CTL);
        wr_data = bus_we && (bus_addr == OFS_DATA);
        wr_addr = bus_we && (bus_addr == OFS_ADDR);
        d       = q;
        job_new = JOB_NONE;
        start   = 1'b0;

        if (done) begin
            if (q.job == JOB_READ) begin
                d.data   = rd_word;
                d.rd_err = rd_fail;
                if (q.job_inc)
                    d.addr = q.addr + 16'd1;
            end
            d.job     = JOB_NONE;
            d.job_inc = 1'b0;
        end

        if (wr_stat) begin
            d.c45 = bus_wdata[STAT_C45_BIT];
            d.div = bus_wdata[STAT_DIV_LSB +: DIV_W];
        end

        if (!busy) begin
            if (wr_ctl) begin
                d.dev    = bus_wdata[CTL_DEV_LSB +: 5];
                d.port   = bus_wdata[CTL_PORT_LSB +: 5];
                d.no_pre = bus_wdata[CTL_NOPRE_BIT];
                d.scan   = bus_wdata[CTL_SCAN_BIT];
                d.inc    = bus_wdata[CTL_INC_BIT];
                if (bus_wdata[CTL_RD_BIT])
                    job_new = JOB_READ;
            end
            if (wr_data) begin
                d.data  = bus_wdata[15:0];
                job_new = JOB_WRITE;
            end
            if (wr_addr) begin
                d.addr = bus_wdata[15:0];
                if (q.c45)
                    job_new = JOB_ADDR;
            end
        end

        if (job_new != JOB_NONE) begin
            start     = 1'b1;
            d.job     = job_new;
            d.job_inc = (job_new == JOB_READ) && q.c45 && d.inc;
            if (job_new == JOB_READ)
                d.rd_err = 1'b0;
        end

        frame.st      = q.c45 ? ST_C45 : ST_C22;
        frame.op      = pick_opcode(q.c45, job_new, d.job_inc);
        frame.port    = d.port;
        frame.dev     = d.dev;
        frame.payload = (job_new == JOB_ADDR) ? d.addr : d.data;
        frame.rd      = (job_new == JOB_READ);
        frame.no_pre  = d.no_pre;
        frame.half    = d.div;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.div <= DIV_RESET;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_STAT: bus_rdata = {16'd0, q.div, 1'b0, q.c45, 4'd0, q.rd_err, busy};
            OFS_CTL:  bus_rdata = {16'd0, 1'b0, q.inc, 2'b00, q.scan, q.no_pre, q.port, q.dev};
            OFS_DATA: bus_rdata = {16'd0, q.data};
            OFS_ADDR: bus_rdata = {16'd0, q.addr};
            default:  bus_rdata = 32'd0;
        endcase
    end

    // R12
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && bus_we && bus_addr == OFS_DATA) |=> (q.data == $past(q.data)));

    // R8
    post_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && q.job == JOB_READ && q.job_inc) |=> (q.addr == $past(q.addr) + 16'd1));

    // R12
    no_launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int               ADDR_W    = 4,
    parameter int               BASE_WORD = 12,
    parameter int               PRE_BITS  = 32,
    parameter logic [DIV_W-1:0] DIV_RESET = 8'd4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              mdc,
    output logic              mdio_out,
    output logic              mdio_oe,
    input  logic              mdio_in
);

    frame_t           frame;
    logic             start, busy, done, run, rise_p, fall_p, rd_fail;
    logic [15:0]      rd_word;
    logic [DIV_W-1:0] half;

    mdio_cfg_regs #(
        .ADDR_W    (ADDR_W),
        .BASE_WORD (BASE_WORD),
        .DIV_RESET (DIV_RESET)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .done      (done),
        .rd_word   (rd_word),
        .rd_fail   (rd_fail),
        .start     (start),
        .frame     (frame)
    );

    mdio_frame_engine #(
        .PRE_BITS (PRE_BITS)
    ) i_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .frame    (frame),
        .rise_p   (rise_p),
        .fall_p   (fall_p),
        .mdio_in  (mdio_in),
        .busy     (busy),
        .run      (run),
        .half     (half),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe),
        .done     (done),
        .rd_word  (rd_word),
        .rd_fail  (rd_fail)
    );

    mdio_clk_div i_clkdiv (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .half   (half),
        .mdc    (mdc),
        .rise_p (rise_p),
        .fall_p (fall_p)
    );

    // R10
    idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

endmodule

// File: tb/test_mdio_mgmt_master.sv
`timescale 1ns/1ps
module test_mdio_mgmt_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = 4'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_out, mdio_oe, mdio_in;

    int checks = 0;
    int failures = 0;

    // bench device model
    logic        phy_on = 1'b1;
    logic [15:0] phy_resp = 16'h0000;
    int          rel_cnt = 0;
    logic        phy_bit;
    logic [63:0] cap = 64'd0;
    int          ccnt = 0;

    localparam logic [3:0] A_STAT = 4'd12;
    localparam logic [3:0] A_CTL  = 4'd13;
    localparam logic [3:0] A_DATA = 4'd14;
    localparam logic [3:0] A_ADDR = 4'd15;

    always #4 clk = ~clk;

    mdio_mgmt_master i_mdio_mgmt_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .mdc       (mdc),
        .mdio_out  (mdio_out),
        .mdio_oe   (mdio_oe),
        .mdio_in   (mdio_in)
    );

    always_comb begin
        phy_bit = 1'b1;
        if (phy_on) begin
            if (rel_cnt == 2)
                phy_bit = 1'b0;
            else if (rel_cnt >= 3 && rel_cnt <= 18)
                phy_bit = phy_resp[18 - rel_cnt];
        end
    end

    assign mdio_in = mdio_oe ? mdio_out : phy_bit;

    always @(posedge mdc) begin
        if (mdio_oe) begin
            rel_cnt <= 0;
            cap     <= {cap[62:0], mdio_out};
            ccnt    <= ccnt + 1;
        end else begin
            rel_cnt <= rel_cnt + 1;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wreg(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = v;
        @(negedge clk);
        bus_we    = 1'b0;
        bus_addr  = A_STAT;
    endtask

    task automatic rreg(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    // launch a frame and count cycles with busy set
    task automatic run_op(input logic [3:0] a, input logic [31:0] v, output int n);
        ccnt = 0;
        wreg(a, v);
        n = 0;
        for (int i = 0; i < 5000; i++) begin
            #1;
            if (!bus_rdata[0]) break;
            n++;
            @(negedge clk);
        end
    endtask

    function automatic logic [31:0] stat_w(input logic c45, input logic [7:0] dv);
        return {16'd0, dv, 1'b0, c45, 6'd0};
    endfunction

    function automatic logic [31:0] ctl_w(input logic [4:0] port, input logic [4:0] dev,
                                          input logic nopre, input logic inc, input logic rd);
        return {16'd0, rd, inc, 2'b00, 1'b0, nopre, port, dev};
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        rreg(A_STAT, v); chk("R1 status", 64'(v), 64'h400);
        rreg(A_CTL, v);  chk("R1 control", 64'(v), 64'h0);
        rreg(A_DATA, v); chk("R1 data", 64'(v), 64'h0);
        rreg(A_ADDR, v); chk("R1 address", 64'(v), 64'h0);
        chk("R1 mdc low", 64'(mdc), 64'h0);
        chk("R1 line released", 64'(mdio_oe), 64'h0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wreg(A_STAT, stat_w(1'b1, 8'h02));
        rreg(A_STAT, v); chk("R2 status fields", 64'(v), 64'h240);
        wreg(A_STAT, stat_w(1'b0, 8'h02));
        wreg(A_CTL, {16'd0, 16'h4C71} | 32'h0000_0800);
        rreg(A_CTL, v); chk("R2 control fields", 64'(v), 64'h4C71);
        wreg(4'd3, 32'hFFFF_FFFF);
        rreg(4'd3, v); chk("R2 reserved reads zero", 64'(v), 64'h0);
        rreg(A_STAT, v); chk("R2 reserved write no effect", 64'(v), 64'h200);
        wreg(A_CTL, ctl_w(5'd3, 5'h11, 1'b0, 1'b0, 1'b0));
        rreg(A_CTL, v); chk("R2 control rewrite", 64'(v), 64'h071);
    endtask

    task automatic t_c22_write();
        int n;
        logic [31:0] v;
        run_op(A_DATA, 32'h0000_A5C3, n);
        chk("R11 busy length c22 write", 64'(n), 64'd261);
        chk("R3 bit count", 64'(ccnt), 64'd64);
        chk("R3 frame", cap, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd3, 5'h11, 2'b10, 16'hA5C3});
        rreg(A_DATA, v); chk("R3 data kept", 64'(v), 64'hA5C3);
        chk("R10 mdc idle low", 64'(mdc), 64'h0);
    endtask

    task automatic t_c22_read();
        int n;
        logic [31:0] v;
        phy_on = 1'b1; phy_resp = 16'h5A69;
        run_op(A_CTL, ctl_w(5'd4, 5'd7, 1'b0, 1'b0, 1'b1), n);
        chk("R11 busy length c22 read", 64'(n), 64'd261);
        chk("R4 driven bits", 64'(ccnt), 64'd46);
        chk("R4 header", 64'(cap[13:0]), 64'({2'b01, 2'b10, 5'd4, 5'd7}));
        rreg(A_DATA, v); chk("R4 read data", 64'(v), 64'h5A69);
        rreg(A_STAT, v); chk("R4 no read error", 64'(v[1]), 64'h0);
        rreg(A_CTL, v); chk("R2 read bit reads zero", 64'(v), 64'h087);
    endtask

    task automatic t_read_err();
        int n;
        logic [31:0] v;
        phy_on = 1'b0;
        run_op(A_CTL, ctl_w(5'd9, 5'd1, 1'b0, 1'b0, 1'b1), n);
        rreg(A_STAT, v); chk("R5 error flag set", 64'(v[1]), 64'h1);
        rreg(A_DATA, v); chk("R5 data all ones", 64'(v), 64'hFFFF);
        phy_on = 1'b1; phy_resp = 16'h0001;
        run_op(A_CTL, ctl_w(5'd9, 5'd1, 1'b0, 1'b0, 1'b1), n);
        rreg(A_STAT, v); chk("R5 error flag cleared", 64'(v[1]), 64'h0);
        rreg(A_DATA, v); chk("R5 good read after error", 64'(v), 64'h0001);
    endtask

    task automatic t_c45();
        int n;
        logic [31:0] v;
        wreg(A_STAT, stat_w(1'b1, 8'h02));
        wreg(A_CTL, ctl_w(5'd2, 5'd1, 1'b0, 1'b0, 1'b0));
        run_op(A_ADDR, 32'h0000_0100, n);
        chk("R6 c45 address busy", 64'(n), 64'd261);
        chk("R6 c45 address frame", cap, {32'hFFFF_FFFF, 2'b00, 2'b00, 5'd2, 5'd1, 2'b10, 16'h0100});
        run_op(A_DATA, 32'h0000_7E81, n);
        chk("R7 c45 write frame", cap, {32'hFFFF_FFFF, 2'b00, 2'b01, 5'd2, 5'd1, 2'b10, 16'h7E81});
        phy_resp = 16'h3C0F;
        run_op(A_CTL, ctl_w(5'd2, 5'd1, 1'b0, 1'b0, 1'b1), n);
        chk("R7 c45 read header", 64'(cap[13:0]), 64'({2'b00, 2'b11, 5'd2, 5'd1}));
        rreg(A_DATA, v); chk("R7 c45 read data", 64'(v), 64'h3C0F);
        rreg(A_ADDR, v); chk("R8 no increment without bit", 64'(v), 64'h0100);
    endtask

    task automatic t_postinc();
        int n;
        logic [31:0] v;
        phy_resp = 16'hC3A5;
        run_op(A_CTL, ctl_w(5'd2, 5'd1, 1'b0, 1'b1, 1'b1), n);
        chk("R8 post-inc opcode", 64'(cap[13:0]), 64'({2'b00, 2'b10, 5'd2, 5'd1}));
        rreg(A_ADDR, v); chk("R8 address incremented", 64'(v), 64'h0101);
        rreg(A_DATA, v); chk("R8 read data", 64'(v), 64'hC3A5);
    endtask

    task automatic t_c22_addr();
        logic [31:0] v;
        wreg(A_STAT, stat_w(1'b0, 8'h02));
        ccnt = 0;
        wreg(A_ADDR, 32'h0000_0042);
        rreg(A_STAT, v); chk("R6 c22 address no busy", 64'(v[0]), 64'h0);
        repeat (20) @(negedge clk);
        chk("R6 c22 address no frame", 64'(ccnt), 64'd0);
        rreg(A_ADDR, v); chk("R6 c22 address stored", 64'(v), 64'h0042);
    endtask

    task automatic t_nopre();
        int n;
        wreg(A_CTL, ctl_w(5'd6, 5'd9, 1'b1, 1'b0, 1'b0));
        run_op(A_DATA, 32'h0000_0F0F, n);
        chk("R11 busy length no preamble", 64'(n), 64'd133);
        chk("R9 bit count", 64'(ccnt), 64'd32);
        chk("R9 frame", 64'(cap[31:0]), 64'({2'b01, 2'b01, 5'd6, 5'd9, 2'b10, 16'h0F0F}));
        wreg(A_CTL, ctl_w(5'd6, 5'd9, 1'b0, 1'b0, 1'b0));
    endtask

    task automatic t_div();
        int n;
        int hi;
        wreg(A_STAT, stat_w(1'b0, 8'h03));
        run_op(A_DATA, 32'h0000_1111, n);
        chk("R11 busy length divider 3", 64'(n), 64'd391);
        wreg(A_STAT, stat_w(1'b0, 8'h00));
        run_op(A_DATA, 32'h0000_2222, n);
        chk("R10 divider zero acts as one", 64'(n), 64'd131);
        wreg(A_STAT, stat_w(1'b0, 8'h03));
        wreg(A_DATA, 32'h0000_3333);
        @(posedge mdc);
        hi = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (!mdc) break;
            hi++;
        end
        chk("R10 mdc high phase", 64'(hi), 64'd3);
        run_op(A_STAT, stat_w(1'b0, 8'h03), n);
        wreg(A_STAT, stat_w(1'b0, 8'h02));
    endtask

    task automatic t_busy_ignore();
        int n;
        logic [31:0] v;
        wreg(A_CTL, ctl_w(5'd1, 5'd2, 1'b0, 1'b0, 1'b0));
        ccnt = 0;
        wreg(A_DATA, 32'h0000_1234);
        repeat (10) @(negedge clk);
        wreg(A_DATA, 32'h0000_BEEF);
        wreg(A_CTL, ctl_w(5'd7, 5'd7, 1'b0, 1'b0, 1'b1));
        wreg(A_ADDR, 32'h0000_5555);
        wreg(A_STAT, stat_w(1'b0, 8'h05));
        rreg(A_STAT, v); chk("R12 status write accepted while busy", 64'(v[15:0]), 64'h0501);
        for (int i = 0; i < 2000; i++) begin
            rreg(A_STAT, v);
            if (!v[0]) break;
        end
        repeat (30) @(negedge clk);
        chk("R12 only one frame", 64'(ccnt), 64'd64);
        chk("R12 frame intact", cap, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd1, 5'd2, 2'b10, 16'h1234});
        rreg(A_DATA, v); chk("R12 data not overwritten", 64'(v), 64'h1234);
        rreg(A_CTL, v);  chk("R12 control not overwritten", 64'(v), 64'h022);
        rreg(A_ADDR, v); chk("R12 address not overwritten", 64'(v), 64'h0042);
        wreg(A_STAT, stat_w(1'b0, 8'h02));
        run_op(A_DATA, 32'h0000_0001, n);
        chk("R11 busy length after busy test", 64'(n), 64'd261);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_c22_write();
        t_c22_read();
        t_read_err();
        t_c45();
        t_postinc();
        t_c22_addr();
        t_nopre();
        t_div();
        t_busy_ignore();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule